// File: doc/BRIEF.md
# Two-Byte Instruction Format Decoder

This block takes a two-byte instruction for an 8-bit machine and splits it into the fields an execution stage needs. The instruction set has no fixed opcode field. The format is picked by escape values in the upper nibble of the first byte, and by the first byte as a whole for a few special cases. A single nibble can carry both a two-bit addressing mode and a two-bit register or unary code. The decoder classifies the instruction and pulls out its fields:

- opcode, register selectors, addressing mode and operand byte;
- shift amount, jump code and IO port number;
- instruction length.

For memory modes it also forms the effective address from the operand byte and the current index register values. Encodings with no defined meaning raise an illegal flag.

Decoding is combinational. All results are captured one clock after the input strobe. When the strobe is low, the outputs keep their last values. Fields that the decoded format does not use are driven to zero.

Top module: `insn_decoder`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. A synchronous active-high `rst` clears `out_valid` and every other output to zero. When `in_valid` is low, all outputs other than `out_valid` keep their values.
- R2: `fmt` takes its value from the first byte:
  - 0: the first byte is 0x00 (halt).
  - 1: the upper nibble is 1..B (register-operand).
  - 2: the first byte is F1..FB (register-register).
  - 3: the first byte is FC or FE (shift).
  - 4: the first byte is FD (unary-register).
  - 5: the upper nibble is D (unary-operand).
  - 6: the upper nibble is E (jump).
  - 7: the first byte is 03 or 04 (port IO).
- R3: Register-operand decoding:
  - `opcode` is the upper nibble of the first byte.
  - `mode` is bits 3:2 of the first byte.
  - `reg_a` is bits 1:0 of the first byte, zero-extended.
  - `operand` is the second byte.
- R4: `mode` values are 0 direct, 1 immediate, 2 indexed by x, 3 indexed by y. In register-operand and unary-operand formats:
  - Any mode other than 1 sets `mem_ref`.
  - Direct mode sets `eff_addr` to the operand byte.
  - Indexed modes set `eff_addr` to the operand byte plus `idx_x` or `idx_y`, modulo 256.
  - In every other case `mem_ref` and `eff_addr` are zero.
- R5: Register-register decoding takes `opcode` from the low nibble of the first byte. `reg_a` is the upper nibble of the second byte and `reg_b` is its lower nibble.
- R6: Shift decoding takes `opcode` from the low nibble of the first byte (C or E). `reg_a` is the upper nibble of the second byte. `shift_amt` is the lower nibble of the second byte, read as a two's-complement value from -8 to 7.
- R7: Unary-register decoding takes `opcode` from the upper nibble of the second byte and `reg_a` from its lower nibble.
- R8: Unary-operand decoding takes `opcode` from bits 1:0 of the first byte, zero-extended. `mode` is bits 3:2 of the first byte and `operand` is the second byte.
- R9: Jump decoding takes `jump_code` from the low nibble of the first byte. `operand` is the second byte.
- R10: `insn_len` is 1 for first byte 0x00 and 2 for every other first byte. For IO:
  - `opcode` is the low nibble of the first byte (3 in, 4 out).
  - `reg_a` is the upper nibble of the second byte.
  - `port_num` is the lower nibble of the second byte.
- R11: `illegal` is set for each of these:
  - a register code of 8 or more in register-register, shift, unary-register or IO format;
  - a unary-register opcode above 4;
  - jump code 5;
  - store (opcode 2) or pop (unary opcode 1) with immediate mode;
  - a first byte of 01, 02 or 05..0F;
  - an upper nibble of C;
  - a first byte of F0 or FF.
  An undecodable first byte gives `fmt` 0 and all fields zero.
- R12: Every field output that the decoded format does not define is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction bytes are present |
| byte0 | input | 8 | First instruction byte |
| byte1 | input | 8 | Second instruction byte |
| idx_x | input | 8 | Current x index register |
| idx_y | input | 8 | Current y index register |
| out_valid | output | 1 | Decoded fields valid |
| fmt | output | 3 | Format tag |
| opcode | output | 4 | Operation code |
| reg_a | output | 4 | First register selector |
| reg_b | output | 4 | Second register selector |
| mode | output | 2 | Addressing mode |
| operand | output | 8 | Operand byte |
| shift_amt | output | 4 | Signed shift amount |
| jump_code | output | 4 | Jump code |
| port_num | output | 4 | IO port number |
| insn_len | output | 2 | Instruction length in bytes |
| mem_ref | output | 1 | Effective address is meaningful |
| eff_addr | output | 8 | Effective memory address |
| illegal | output | 1 | Encoding is not defined |

## Verification
The decoder is driven with every one of the 65536 combinations of the two bytes, back to back with no gaps. Each format, every reserved register code, every mode and every escape combination therefore shows up in the same run.

The index registers are derived from the bytes themselves, so they differ from vector to vector. Some of them push the indexed sum past 255; this separates x from y and makes the wraparound visible.

After the sweep, idle cycles confirm that the outputs hold their values. A mid-run reset confirms that the outputs clear.

// File: rtl/insn_decoder.sv
module insn_decoder #(
  parameter int NREG = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] byte0,
  input  logic [7:0] byte1,
  input  logic [7:0] idx_x,
  input  logic [7:0] idx_y,
  output logic       out_valid,
  output logic [2:0] fmt,
  output logic [3:0] opcode,
  output logic [3:0] reg_a,
  output logic [3:0] reg_b,
  output logic [1:0] mode,
  output logic [7:0] operand,
  output logic [3:0] shift_amt,
  output logic [3:0] jump_code,
  output logic [3:0] port_num,
  output logic [1:0] insn_len,
  output logic       mem_ref,
  output logic [7:0] eff_addr,
  output logic       illegal
);
  localparam logic [2:0] F_HALT = 3'd0, F_RO = 3'd1, F_RR = 3'd2, F_SH = 3'd3,
                         F_UR = 3'd4, F_UO = 3'd5, F_JP = 3'd6, F_IO = 3'd7;
  localparam logic [1:0] M_DIR = 2'd0, M_IMM = 2'd1, M_IX = 2'd2;

  logic [3:0] hi0, lo0, hi1, lo1;
  assign hi0 = byte0[7:4];
  assign lo0 = byte0[3:0];
  assign hi1 = byte1[7:4];
  assign lo1 = byte1[3:0];

  logic hi1_bad, lo1_bad;
  assign hi1_bad = int'(hi1) >= NREG;
  assign lo1_bad = int'(lo1) >= NREG;

  logic [1:0] m2;
  logic [7:0] ea_calc;
  logic       ea_mem;
  assign m2 = byte0[3:2];
  assign ea_mem = (m2 != M_IMM);
  always_comb begin
    case (m2)
      M_DIR:   ea_calc = byte1;
      M_IX:    ea_calc = byte1 + idx_x;
      M_IMM:   ea_calc = 8'h00;
      default: ea_calc = byte1 + idx_y;
    endcase
  end

  logic [2:0] d_fmt;
  logic [3:0] d_op, d_ra, d_rb, d_sh, d_jc, d_port;
  logic [1:0] d_mode, d_len;
  logic [7:0] d_opnd, d_ea;
  logic       d_mem, d_ill;

  always_comb begin
    d_fmt = F_HALT; d_op = '0; d_ra = '0; d_rb = '0; d_mode = '0;
    d_opnd = '0; d_sh = '0; d_jc = '0; d_port = '0; d_len = 2'd2;
    d_mem = 1'b0; d_ea = '0; d_ill = 1'b0;
    case (hi0)
      4'h0: begin
        if (lo0 == 4'h0) d_len = 2'd1;
        else if (lo0 == 4'h3 || lo0 == 4'h4) begin
          d_fmt = F_IO; d_op = lo0; d_ra = hi1; d_port = lo1; d_ill = hi1_bad;
        end else d_ill = 1'b1;
      end
      4'hC: d_ill = 1'b1;
      4'hD: begin
        d_fmt = F_UO; d_op = {2'b00, byte0[1:0]}; d_mode = m2; d_opnd = byte1;
        d_mem = ea_mem; d_ea = ea_calc;
        d_ill = (byte0[1:0] == 2'd1) && (m2 == M_IMM);
      end
      4'hE: begin
        d_fmt = F_JP; d_jc = lo0; d_opnd = byte1; d_ill = (lo0 == 4'h5);
      end
      4'hF: begin
        case (lo0)
          4'h0, 4'hF: d_ill = 1'b1;
          4'hC, 4'hE: begin
            d_fmt = F_SH; d_op = lo0; d_ra = hi1; d_sh = lo1; d_ill = hi1_bad;
          end
          4'hD: begin
            d_fmt = F_UR; d_op = hi1; d_ra = lo1;
            d_ill = lo1_bad || (hi1 > 4'h4);
          end
          default: begin
            d_fmt = F_RR; d_op = lo0; d_ra = hi1; d_rb = lo1;
            d_ill = hi1_bad || lo1_bad;
          end
        endcase
      end
      default: begin
        d_fmt = F_RO; d_op = hi0; d_mode = m2; d_ra = {2'b00, byte0[1:0]};
        d_opnd = byte1; d_mem = ea_mem; d_ea = ea_calc;
        d_ill = (hi0 == 4'h2) && (m2 == M_IMM);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; fmt <= '0; opcode <= '0; reg_a <= '0; reg_b <= '0;
      mode <= '0; operand <= '0; shift_amt <= '0; jump_code <= '0;
      port_num <= '0; insn_len <= '0; mem_ref <= 1'b0; eff_addr <= '0;
      illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fmt <= d_fmt; opcode <= d_op; reg_a <= d_ra; reg_b <= d_rb;
        mode <= d_mode; operand <= d_opnd; shift_amt <= d_sh; jump_code <= d_jc;
        port_num <= d_port; insn_len <= d_len; mem_ref <= d_mem; eff_addr <= d_ea;
        illegal <= d_ill;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(fmt) && $stable(eff_addr) && $stable(operand));
  assert_index_x_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && (byte0[7:4] == 4'hD) && (byte0[3:2] == 2'd2)
    |=> eff_addr == 8'($past(byte1) + $past(idx_x)));
  assert_no_addr_without_mem_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !mem_ref |-> eff_addr == 8'h00);
  assert_shift_opcode_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && fmt == F_SH |-> opcode == 4'hC || opcode == 4'hE);
  assert_unreg_legal_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && fmt == F_UR && !illegal |-> opcode <= 4'h4 && int'(reg_a) < NREG);
  assert_len_one_halt_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && insn_len == 2'd1 |-> fmt == F_HALT && !illegal);
endmodule

// File: tb/sim_insn_decoder.sv
module sim_insn_decoder;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [7:0] byte0 = '0, byte1 = '0, idx_x = '0, idx_y = '0;
  logic out_valid, mem_ref, illegal;
  logic [2:0] fmt;
  logic [3:0] opcode, reg_a, reg_b, shift_amt, jump_code, port_num;
  logic [1:0] mode, insn_len;
  logic [7:0] operand, eff_addr;

  insn_decoder u0 (.clk, .rst, .in_valid, .byte0, .byte1, .idx_x, .idx_y,
    .out_valid, .fmt, .opcode, .reg_a, .reg_b, .mode, .operand, .shift_amt,
    .jump_code, .port_num, .insn_len, .mem_ref, .eff_addr, .illegal);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  int e_fmt, e_op, e_ra, e_rb, e_mode, e_opnd, e_sh, e_jc, e_port, e_len, e_mem, e_ea, e_ill;
  string e_rq;

  task automatic model(input int b0, input int b1, input int x, input int y);
    int h0, l0, h1, l1, m;
    h0 = b0 / 16; l0 = b0 % 16; h1 = b1 / 16; l1 = b1 % 16; m = l0 / 4;
    e_fmt = 0; e_op = 0; e_ra = 0; e_rb = 0; e_mode = 0; e_opnd = 0; e_sh = 0;
    e_jc = 0; e_port = 0; e_len = 2; e_mem = 0; e_ea = 0; e_ill = 0; e_rq = "R12";
    if (b0 == 0) e_len = 1;
    else if (b0 == 3 || b0 == 4) begin
      e_fmt = 7; e_op = b0; e_ra = h1; e_port = l1; e_ill = (h1 >= 8); e_rq = "R10";
    end else if (h0 >= 1 && h0 <= 11) begin
      e_fmt = 1; e_op = h0; e_mode = m; e_ra = l0 % 4; e_opnd = b1; e_rq = "R3";
      e_ill = (h0 == 2 && m == 1);
    end else if (h0 == 13) begin
      e_fmt = 5; e_op = l0 % 4; e_mode = m; e_opnd = b1; e_rq = "R8";
      e_ill = (l0 % 4 == 1 && m == 1);
    end else if (h0 == 14) begin
      e_fmt = 6; e_jc = l0; e_opnd = b1; e_ill = (l0 == 5); e_rq = "R9";
    end else if (h0 == 15 && l0 >= 1 && l0 <= 11) begin
      e_fmt = 2; e_op = l0; e_ra = h1; e_rb = l1; e_ill = (h1 >= 8 || l1 >= 8); e_rq = "R5";
    end else if (b0 == 8'hFC || b0 == 8'hFE) begin
      e_fmt = 3; e_op = l0; e_ra = h1; e_sh = l1; e_ill = (h1 >= 8); e_rq = "R6";
    end else if (b0 == 8'hFD) begin
      e_fmt = 4; e_op = h1; e_ra = l1; e_ill = (h1 > 4 || l1 >= 8); e_rq = "R7";
    end else e_ill = 1;
    if (e_fmt == 1 || e_fmt == 5) begin
      e_mem = (m != 1);
      if (m == 0) e_ea = b1;
      else if (m == 2) e_ea = (b1 + x) % 256;
      else if (m == 3) e_ea = (b1 + y) % 256;
    end
  endtask

  task automatic compare_all();
    chk("R1", "out_valid", int'(out_valid), 1);
    chk("R2", "fmt", int'(fmt), e_fmt);
    chk(e_rq, "opcode", int'(opcode), e_op);
    chk(e_rq, "reg_a", int'(reg_a), e_ra);
    chk(e_rq, "reg_b", int'(reg_b), e_rb);
    chk(e_rq, "mode", int'(mode), e_mode);
    chk(e_rq, "operand", int'(operand), e_opnd);
    chk(e_rq, "shift_amt", int'(shift_amt), e_sh);
    chk(e_rq, "jump_code", int'(jump_code), e_jc);
    chk(e_rq, "port_num", int'(port_num), e_port);
    chk("R10", "insn_len", int'(insn_len), e_len);
    chk("R4", "mem_ref", int'(mem_ref), e_mem);
    chk("R4", "eff_addr", int'(eff_addr), e_ea);
    chk("R11", "illegal", int'(illegal), e_ill);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset out_valid", int'(out_valid), 0);
    chk("R1", "reset fmt", int'(fmt), 0);
    chk("R1", "reset insn_len", int'(insn_len), 0);
    chk("R1", "reset illegal", int'(illegal), 0);
    rst = 1'b0;
    // exhaustive sweep; R2..R12 checked per vector, R4 wraps via large index values
    for (int i = 0; i < 65536; i++) begin
      if (i > 0) compare_all();
      byte0 = 8'(i >> 8);
      byte1 = 8'(i);
      idx_x = 8'((i >> 8) + 200);
      idx_y = 8'((i ^ (i >> 8)) + 8'h9B);
      in_valid = 1'b1;
      model(int'(byte0), int'(byte1), int'(idx_x), int'(idx_y));
      @(negedge clk);
    end
    compare_all();
    // R1: idle cycles hold fields and drop out_valid
    in_valid = 1'b0;
    byte0 = 8'h00; byte1 = 8'h00;
    repeat (2) @(negedge clk);
    chk("R1", "idle out_valid", int'(out_valid), 0);
    chk("R1", "idle hold fmt", int'(fmt), e_fmt);
    chk("R1", "idle hold reg_a", int'(reg_a), e_ra);
    chk("R1", "idle hold insn_len", int'(insn_len), e_len);
    // R4: specific wrap case, indexed by y
    byte0 = 8'h2D; byte1 = 8'h51; idx_y = 8'hFE; idx_x = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4", "wrap eff_addr", int'(eff_addr), 8'h4F);
    chk("R3", "store opcode", int'(opcode), 2);
    // R1: reset clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset2 eff_addr", int'(eff_addr), 0);
    chk("R1", "reset2 opcode", int'(opcode), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule